// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM

This block is a synchronous static memory with a small internal array, built so that reads and writes share one fixed data latency of two clock edges. A command (load or advance, read or write, per-byte write masks, three chip-select inputs) is sampled on a rising edge. Read data leaves the block, and write data is taken in, two rising edges later. Because both directions use the same slot, a write can follow a read, or a read can follow a write, on consecutive cycles with no idle cycle in between. A read issued right behind a write to the same word returns the newly written bytes.

A load cycle either starts a new access at the presented address or, when the chip is not selected, starts a deselect. An advance cycle continues the current burst from an internal two-bit counter, in linear or interleaved order, and ignores the address pins. A clock-enable input and a sleep input both freeze the whole block, and the array keeps its contents while frozen. The output path uses separate data-in and data-out ports and a drive-enable flag instead of a tristate pin. The drive-enable is gated at once by an output-enable input.

Top module: `zbt_sram`

## Requirements
- R1: While reset is asserted and just after it is released, `dout_en` is 0 and `dout` is all zeros.
- R2: A selected load with `rd_n`=1 at rising edge k sets `dout_en` and puts the word at that address on `dout` right after edge k+2. A selected load with `rd_n`=0 at edge k writes the `din` sampled at edge k+2. Edges count only when the block is not frozen.
- R3: Reads and writes can be issued on every cycle in any mix. A read issued one cycle after a write to the same address returns the bytes that write stores.
- R4: `bwe_n` holds one active-low enable per 9-bit lane, and lane b is bits 9b+8..9b. It is sampled with each write beat. Lanes with a 1 keep their old contents. `bwe_n` has no effect on reads.
- R5: The chip is selected only when `cs_a_n`=0, `cs_b_n`=0 and `cs_p`=1. A load (`adv_ld`=0) while not selected starts a deselect, and `dout_en` is 0 two edges later.
- R6: An advance (`adv_ld`=1) during a burst issues the next beat with the operation type of the load. The upper address bits come from the load. For a start offset s and beat n (1..3, wrapping mod 4), the low two bits are (s+n) mod 4 when `burst_ord`=0 and s XOR n when `burst_ord`=1.
- R7: An advance when no burst is active (after reset or after a deselect) issues nothing, and the `addr` pins have no effect on it.
- R8: When `clk_en_n` is 1 at an edge, all synchronous inputs are ignored, and the pipeline, the burst state and the outputs hold their values.
- R9: When `oe_n` is 1, `dout_en` is 0 and `dout` is all zeros at once, with no clock edge needed. The pipeline keeps going, so data that is due appears as soon as `oe_n` returns to 0.
- R10: When `sleep` is 1, the block is frozen as in R8 and the array keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of pipeline, burst and output state |
| sleep | input | 1 | High freezes the block; contents retained |
| clk_en_n | input | 1 | Active-low clock enable |
| cs_a_n | input | 1 | Active-low chip select A |
| cs_b_n | input | 1 | Active-low chip select B |
| cs_p | input | 1 | Active-high chip select |
| adv_ld | input | 1 | 0 = load new command, 1 = advance burst |
| rd_n | input | 1 | On a load: 1 = read, 0 = write |
| bwe_n | input | NBYTES | Active-low per-lane write enables |
| burst_ord | input | 1 | 0 = linear, 1 = interleaved burst order; static |
| addr | input | ADDR_W | Word address, used on loads |
| oe_n | input | 1 | Asynchronous active-low output enable |
| din | input | NBYTES*BYTE_W | Write data, sampled in the data slot |
| dout | output | NBYTES*BYTE_W | Read data, zero outside a driven slot |
| dout_en | output | 1 | High while `dout` carries read data |

## Verification
On every cycle, the assertions check that a read load leads to a read slot two active edges later and that a deselect load leads to a released bus. They also check that a freeze from the clock enable or from sleep holds the pipeline and the output stage, and that a masked write lane leaves its stored bits unchanged. Only the bench scenarios can show the data values: the forwarding of a just-written word into an immediately following read, the two burst orders with their wrap, advances ignored after a deselect, the output-enable gating, and array contents that survive a sleep period.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

   // Order in which burst beats walk the low address bits
   typedef enum logic {
      ORD_LINEAR = 1'b0,
      ORD_XOR    = 1'b1
   } burst_ord_e;

   // Operation carried by one pipeline slot
   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2
   } op_e;

endpackage

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq
   import zbt_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int BURST_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              adv_ld,
   input  logic              rd_n,
   input  logic              sel_ok,
   input  burst_ord_e        order,
   input  logic [ADDR_W-1:0] addr,
   output op_e               iss_op,
   output logic [ADDR_W-1:0] iss_addr
);

   localparam int HI_W = ADDR_W - BURST_BITS;

   if (ADDR_W <= BURST_BITS) begin : g_bad_width
      $error("zbt_burst_seq: ADDR_W must exceed BURST_BITS");
   end
   if (BURST_BITS < 1) begin : g_bad_burst
      $error("zbt_burst_seq: BURST_BITS must be at least 1");
   end

   logic                  act_q;
   op_e                   bop_q;
   logic [ADDR_W-1:0]     base_q;
   logic [BURST_BITS-1:0] cnt_q;
   logic [BURST_BITS-1:0] cnt_nx;
   logic [BURST_BITS-1:0] lo_seq;
   logic [HI_W-1:0]       hi_base;

   assign cnt_nx  = cnt_q + 1'b1;
   assign hi_base = base_q[ADDR_W-1:BURST_BITS];

   always_comb begin
      if (order == ORD_XOR) lo_seq = base_q[BURST_BITS-1:0] ^ cnt_nx;
      else                  lo_seq = base_q[BURST_BITS-1:0] + cnt_nx;
   end

   always_comb begin
      iss_op   = OP_NONE;
      iss_addr = addr;
      if (!adv_ld) begin
         if (sel_ok) iss_op = rd_n ? OP_RD : OP_WR;
      end else if (act_q) begin
         iss_op   = bop_q;
         iss_addr = {hi_base, lo_seq};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         bop_q  <= OP_NONE;
         base_q <= '0;
         cnt_q  <= '0;
      end else if (step) begin
         if (!adv_ld) begin
            act_q  <= sel_ok;
            base_q <= addr;
            cnt_q  <= '0;
            bop_q  <= rd_n ? OP_RD : OP_WR;
         end else if (act_q) begin
            cnt_q <= cnt_nx;
         end
      end
   end

   AST_NO_BURST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      step && !adv_ld && !sel_ok |=> !(adv_ld && iss_op != OP_NONE))
      else $error("advance issued a beat after a deselect"); // R7

endmodule

// File: rtl/zbt_cmd_pipe.sv
module zbt_cmd_pipe
   import zbt_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int NBYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  op_e               in_op,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [NBYTES-1:0] in_bwe_n,
   output op_e               s1_op,
   output logic [ADDR_W-1:0] s1_addr,
   output op_e               s2_op,
   output logic [ADDR_W-1:0] s2_addr,
   output logic [NBYTES-1:0] s2_bwe_n
);

   localparam int STAGES = 2;

   op_e               op_q   [STAGES];
   logic [ADDR_W-1:0] addr_q [STAGES];
   logic [NBYTES-1:0] bwe_q  [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) begin
            op_q[i]   <= OP_NONE;
            addr_q[i] <= '0;
            bwe_q[i]  <= '1;
         end
      end else if (step) begin
         op_q[0]   <= in_op;
         addr_q[0] <= in_addr;
         bwe_q[0]  <= in_bwe_n;
         for (int i = 1; i < STAGES; i++) begin
            op_q[i]   <= op_q[i-1];
            addr_q[i] <= addr_q[i-1];
            bwe_q[i]  <= bwe_q[i-1];
         end
      end
   end

   assign s1_op    = op_q[0];
   assign s1_addr  = addr_q[0];
   assign s2_op    = op_q[STAGES-1];
   assign s2_addr  = addr_q[STAGES-1];
   assign s2_bwe_n = bwe_q[STAGES-1];

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(op_q[0]) && $stable(op_q[STAGES-1]) && $stable(addr_q[STAGES-1]))
      else $error("pipeline moved while frozen"); // R8

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
   parameter int ADDR_W = 8,
   parameter int NBYTES = 4,
   parameter int BYTE_W = 9
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     step,
   input  logic [ADDR_W-1:0]        rd_addr,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [NBYTES-1:0]        wr_bwe_n,
   input  logic [NBYTES*BYTE_W-1:0] din,
   output logic [NBYTES*BYTE_W-1:0] rd_q
);

   localparam int DATA_W = NBYTES * BYTE_W;
   localparam int DEPTH  = 1 << ADDR_W;

   if (ADDR_W > 12) begin : g_too_deep
      $error("zbt_array: ADDR_W above 12 makes the array too large");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] fwd;
   logic              hit;

   assign hit = wr_en && (wr_addr == rd_addr);

   // One lane per byte: forward the write that commits on this same edge
   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      assign fwd[b*BYTE_W +: BYTE_W] = (hit && !wr_bwe_n[b]) ? din[b*BYTE_W +: BYTE_W]
                                                              : mem[rd_addr][b*BYTE_W +: BYTE_W];

      AST_LANE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
         step && wr_en && wr_bwe_n[b] |=>
            mem[$past(wr_addr)][b*BYTE_W +: BYTE_W] == $past(mem[wr_addr][b*BYTE_W +: BYTE_W]))
         else $error("masked lane was overwritten"); // R4
   end

   always_ff @(posedge clk) begin
      if (step && wr_en) begin
         for (int b = 0; b < NBYTES; b++) begin
            if (!wr_bwe_n[b]) mem[wr_addr][b*BYTE_W +: BYTE_W] <= din[b*BYTE_W +: BYTE_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rd_q <= '0;
      else if (step) rd_q <= fwd;
   end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
   import zbt_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int NBYTES     = 4,
   parameter int BYTE_W     = 9,
   parameter int BURST_BITS = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sleep,
   input  logic                     clk_en_n,
   input  logic                     cs_a_n,
   input  logic                     cs_b_n,
   input  logic                     cs_p,
   input  logic                     adv_ld,
   input  logic                     rd_n,
   input  logic [NBYTES-1:0]        bwe_n,
   input  logic                     burst_ord,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     oe_n,
   input  logic [NBYTES*BYTE_W-1:0] din,
   output logic [NBYTES*BYTE_W-1:0] dout,
   output logic                     dout_en
);

   localparam int DATA_W = NBYTES * BYTE_W;

   if (NBYTES < 1 || BYTE_W < 1) begin : g_bad_lanes
      $error("zbt_sram: NBYTES and BYTE_W must be positive");
   end

   logic              step;
   logic              sel_ok;
   op_e               iss_op;
   logic [ADDR_W-1:0] iss_addr;
   op_e               s1_op;
   logic [ADDR_W-1:0] s1_addr;
   op_e               s2_op;
   logic [ADDR_W-1:0] s2_addr;
   logic [NBYTES-1:0] s2_bwe_n;
   logic [DATA_W-1:0] rd_q;
   logic [DATA_W-1:0] dout_q;
   logic              slot_q;

   assign step   = !clk_en_n && !sleep;
   assign sel_ok = !cs_a_n && !cs_b_n && cs_p;

   zbt_burst_seq #(
      .ADDR_W     (ADDR_W),
      .BURST_BITS (BURST_BITS)
   ) i_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .adv_ld   (adv_ld),
      .rd_n     (rd_n),
      .sel_ok   (sel_ok),
      .order    (burst_ord_e'(burst_ord)),
      .addr     (addr),
      .iss_op   (iss_op),
      .iss_addr (iss_addr)
   );

   zbt_cmd_pipe #(
      .ADDR_W (ADDR_W),
      .NBYTES (NBYTES)
   ) i_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .in_op    (iss_op),
      .in_addr  (iss_addr),
      .in_bwe_n (bwe_n),
      .s1_op    (s1_op),
      .s1_addr  (s1_addr),
      .s2_op    (s2_op),
      .s2_addr  (s2_addr),
      .s2_bwe_n (s2_bwe_n)
   );

   zbt_array #(
      .ADDR_W (ADDR_W),
      .NBYTES (NBYTES),
      .BYTE_W (BYTE_W)
   ) i_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .rd_addr  (s1_addr),
      .wr_en    (s2_op == OP_WR),
      .wr_addr  (s2_addr),
      .wr_bwe_n (s2_bwe_n),
      .din      (din),
      .rd_q     (rd_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= 1'b0;
         dout_q <= '0;
      end else if (step) begin
         slot_q <= (s2_op == OP_RD);
         if (s2_op == OP_RD) dout_q <= rd_q;
      end
   end

   assign dout_en = slot_q && !oe_n;
   assign dout    = dout_en ? dout_q : '0;

   // Checking support: edges seen since reset release, saturating
   logic [1:0] rst_age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              rst_age <= '0;
      else if (rst_age != 2'd3) rst_age <= rst_age + 2'd1;
   end

   AST_RD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      rst_age >= 2'd2 && step && $past(step) && $past(step && iss_op == OP_RD, 2) |=> slot_q)
      else $error("read load did not reach its data slot"); // R2

   AST_DESEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_age >= 2'd2 && step && $past(step) && $past(step && !adv_ld && !sel_ok, 2) |=> !slot_q)
      else $error("bus still driven after deselect"); // R5

   AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> $stable(slot_q) && $stable(dout_q))
      else $error("output stage changed during sleep"); // R10

endmodule

// File: tb/test_zbt_sram.sv
`timescale 1ns/1ps
module test_zbt_sram;

   localparam real CLK_P = 4.0;
   localparam int  AW    = 8;
   localparam int  NB    = 4;
   localparam int  BW    = 9;
   localparam int  DW    = NB * BW;

   typedef struct {
      bit          vld;
      bit          wr;
      int unsigned adr;
      bit [NB-1:0] bwe;
   } op_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sleep = 1'b0;
   logic          clk_en_n = 1'b1;
   logic          cs_a_n = 1'b1;
   logic          cs_b_n = 1'b1;
   logic          cs_p = 1'b0;
   logic          adv_ld = 1'b0;
   logic          rd_n = 1'b1;
   logic [NB-1:0] bwe_n = '1;
   logic          burst_ord = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          oe_n = 1'b0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_en;

   always #(CLK_P/2) clk = ~clk;

   zbt_sram i_zbt_sram (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .clk_en_n(clk_en_n),
      .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .cs_p(cs_p), .adv_ld(adv_ld),
      .rd_n(rd_n), .bwe_n(bwe_n), .burst_ord(burst_ord), .addr(addr),
      .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en)
   );

   // Staged inputs for the next cycle
   logic          nx_cen_n = 1'b0, nx_sleep = 1'b0, nx_oe_n = 1'b0;
   logic          nx_a_n = 1'b1, nx_b_n = 1'b1, nx_p = 1'b0;
   logic          nx_adv = 1'b0, nx_rd_n = 1'b1, nx_ord = 1'b0;
   logic [NB-1:0] nx_bwe = '1;
   logic [AW-1:0] nx_addr = '0;

   // Reference model state
   logic [DW-1:0] mdl [256];
   op_t           pend [$];
   bit            b_act = 0;
   bit            b_wr = 0;
   int unsigned   b_base = 0;
   int unsigned   b_cnt = 0;
   bit            exp_slot = 0;
   logic [DW-1:0] exp_q = '0;
   int            salt = 0;
   string         cur_req = "R1";

   int  n_chk = 0;
   int  n_err = 0;
   bit  finished = 0;

   function automatic logic [DW-1:0] pat(int unsigned a, int s);
      logic [7:0] a8 = 8'(a);
      logic [7:0] s8 = 8'(s);
      return {s8[3:0], a8, 8'(a8 * 8'd7 + s8), a8 ^ 8'h5a ^ s8, 8'(s8 * 8'd13 + a8)};
   endfunction

   task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      bit e_en = exp_slot && !oe_n;
      chk(cur_req, "dout_en", DW'(dout_en), DW'(e_en));
      chk(cur_req, "dout", dout, e_en ? exp_q : '0);
   endtask

   // Behavioural model of one rising edge with the inputs now on the pins
   task automatic model_edge();
      op_t op;
      op_t d;
      int unsigned lo;
      if (!(rst_n && !clk_en_n && !sleep)) return;
      op.vld = 0; op.wr = 0; op.adr = 0; op.bwe = bwe_n;
      if (!adv_ld) begin
         if (!cs_a_n && !cs_b_n && cs_p) begin
            op.vld = 1; op.wr = !rd_n; op.adr = addr;
            b_act = 1; b_base = addr; b_cnt = 0; b_wr = !rd_n;
         end else begin
            b_act = 0;
         end
      end else if (b_act) begin
         b_cnt = (b_cnt + 1) % 4;
         lo = burst_ord ? ((b_base % 4) ^ b_cnt) : (((b_base % 4) + b_cnt) % 4);
         op.vld = 1; op.wr = b_wr; op.adr = (b_base / 4) * 4 + lo;
      end
      pend.push_back(op);
      d = pend.pop_front();
      if (d.vld && d.wr) begin
         for (int b = 0; b < NB; b++)
            if (!d.bwe[b]) mdl[d.adr][b*BW +: BW] = din[b*BW +: BW];
      end
      exp_slot = d.vld && !d.wr;
      if (exp_slot) exp_q = mdl[d.adr];
   endtask

   task automatic tick();
      @(negedge clk);
      compare();
      clk_en_n = nx_cen_n; sleep = nx_sleep; oe_n = nx_oe_n;
      cs_a_n = nx_a_n; cs_b_n = nx_b_n; cs_p = nx_p;
      adv_ld = nx_adv; rd_n = nx_rd_n; burst_ord = nx_ord;
      bwe_n = nx_bwe; addr = nx_addr;
      // Data slot of the oldest pending command gets its write data
      if (pend[0].vld && pend[0].wr) din = pat(pend[0].adr, salt);
      else                           din = {DW{1'b1}} ^ pat(nx_addr, salt + 9);
      model_edge();
   endtask

   task automatic cmd(bit adv, bit rdn, int unsigned a, logic [NB-1:0] bw);
      nx_a_n = 0; nx_b_n = 0; nx_p = 1;
      nx_adv = adv; nx_rd_n = rdn; nx_addr = AW'(a); nx_bwe = bw;
      tick();
   endtask

   task automatic desel(int n);
      for (int i = 0; i < n; i++) begin
         nx_a_n = 0; nx_b_n = 0; nx_p = 0;
         nx_adv = 0; nx_rd_n = 1; nx_addr = AW'(i * 17); nx_bwe = '1;
         tick();
      end
   endtask

   initial begin
      pend.push_back('{vld:0, wr:0, adr:0, bwe:'1});
      pend.push_back('{vld:0, wr:0, adr:0, bwe:'1});
      repeat (3) @(negedge clk);
      // R1: bus released in and right after reset
      chk("R1", "dout_en in reset", DW'(dout_en), '0);
      chk("R1", "dout in reset", dout, '0);
      rst_n = 1'b1;
      chk("R1", "dout_en after reset", DW'(dout_en), '0);
      chk("R1", "dout after reset", dout, '0);
      desel(2);

      // R2: fill the whole array with full-width writes, then read back
      cur_req = "R2"; salt = 0;
      for (int a = 0; a < 256; a++) cmd(0, 0, a, 4'h0);
      desel(3);
      cmd(0, 1, 3, 4'h0); cmd(0, 1, 200, 4'h0); cmd(0, 1, 77, 4'h0);
      cmd(0, 1, 255, 4'h0); cmd(0, 1, 0, 4'h0);
      desel(3);

      // R3: mixed traffic, read right behind write to the same word
      cur_req = "R3"; salt = 1;
      cmd(0, 0, 20, 4'h0); cmd(0, 1, 20, 4'h0); cmd(0, 0, 21, 4'h0);
      cmd(0, 1, 21, 4'h0); cmd(0, 1, 20, 4'h0); cmd(0, 0, 22, 4'h0);
      cmd(0, 1, 22, 4'h0); cmd(0, 0, 23, 4'h0); cmd(0, 0, 24, 4'h0);
      cmd(0, 1, 23, 4'h0); cmd(0, 1, 24, 4'h0);
      desel(3);

      // R4: lane masks on writes, masks ignored on reads
      cur_req = "R4"; salt = 2;
      cmd(0, 0, 30, 4'b0101); cmd(0, 1, 30, 4'b1111);
      cmd(0, 0, 31, 4'b1110); cmd(0, 1, 31, 4'b0000);
      cmd(0, 0, 32, 4'b1111); cmd(0, 1, 32, 4'b0000);
      cmd(0, 1, 30, 4'b0000);
      desel(3);

      // R5: each chip-select input alone deselects
      cur_req = "R5";
      cmd(0, 1, 40, 4'h0);
      nx_a_n = 0; nx_b_n = 0; nx_p = 0; nx_adv = 0; nx_rd_n = 1; nx_addr = 41; tick();
      nx_a_n = 1; nx_b_n = 0; nx_p = 1; tick();
      nx_a_n = 0; nx_b_n = 1; nx_p = 1; tick();
      cmd(0, 1, 41, 4'h0);
      nx_a_n = 0; nx_b_n = 0; nx_p = 0; nx_adv = 0; nx_rd_n = 0; nx_addr = 42; tick();
      desel(3);

      // R6: linear read burst, interleaved write and read bursts
      cur_req = "R6"; salt = 3;
      nx_ord = 0; desel(1);
      cmd(0, 1, 8'h16, 4'h0); cmd(1, 1, 0, 4'h0); cmd(1, 1, 0, 4'h0); cmd(1, 1, 0, 4'h0);
      cmd(1, 1, 0, 4'h0);
      cmd(0, 0, 8'h45, 4'h0); cmd(1, 0, 0, 4'b0011); cmd(1, 0, 0, 4'b1100); cmd(1, 0, 0, 4'h0);
      cmd(0, 1, 8'h44, 4'h0); cmd(1, 1, 0, 4'h0); cmd(1, 1, 0, 4'h0); cmd(1, 1, 0, 4'h0);
      desel(3);
      nx_ord = 1; desel(1);
      cmd(0, 0, 8'h2d, 4'h0); cmd(1, 0, 9, 4'h0); cmd(1, 0, 9, 4'b1010); cmd(1, 0, 9, 4'h0);
      cmd(0, 1, 8'h2c, 4'h0); cmd(1, 1, 0, 4'h0); cmd(1, 1, 0, 4'h0); cmd(1, 1, 0, 4'h0);
      cmd(0, 1, 8'h2e, 4'h0); cmd(1, 1, 0, 4'h0); cmd(1, 1, 0, 4'h0); cmd(1, 1, 0, 4'h0);
      desel(3);
      nx_ord = 0; desel(1);

      // R7: advances with no burst in progress issue nothing
      cur_req = "R7";
      cmd(1, 1, 90, 4'h0); cmd(1, 0, 91, 4'h0); cmd(1, 1, 92, 4'h0);
      cmd(0, 1, 8'h50, 4'h0); cmd(1, 1, 0, 4'h0);
      desel(1);
      cmd(1, 1, 93, 4'h0); cmd(1, 0, 94, 4'h0);
      desel(3);

      // R8: clock enable high freezes pipeline and outputs
      cur_req = "R8"; salt = 4;
      cmd(0, 1, 5, 4'h0); cmd(0, 0, 6, 4'h0);
      nx_cen_n = 1;
      cmd(0, 0, 99, 4'h0); cmd(0, 1, 98, 4'h0); cmd(1, 0, 97, 4'h0);
      nx_cen_n = 0;
      cmd(0, 1, 6, 4'h0); cmd(0, 1, 99, 4'h0);
      desel(1);
      nx_cen_n = 1; desel(2); nx_cen_n = 0;
      desel(3);

      // R9: output enable gates the bus while the pipeline runs
      cur_req = "R9";
      cmd(0, 1, 7, 4'h0); cmd(0, 1, 8, 4'h0);
      nx_oe_n = 1; cmd(0, 1, 9, 4'h0);
      nx_oe_n = 0; cmd(0, 1, 10, 4'h0);
      nx_oe_n = 1; cmd(0, 1, 11, 4'h0);
      nx_oe_n = 1; desel(1);
      nx_oe_n = 0; desel(3);

      // R10: sleep freezes the block and keeps array contents
      cur_req = "R10"; salt = 5;
      cmd(0, 0, 60, 4'h0); cmd(0, 1, 61, 4'h0);
      nx_sleep = 1;
      cmd(0, 0, 60, 4'h0); cmd(0, 0, 61, 4'h0); cmd(1, 1, 62, 4'h0); desel(2);
      nx_sleep = 0;
      cmd(0, 1, 60, 4'h0); cmd(0, 1, 61, 4'h0); cmd(0, 1, 22, 4'h0);
      desel(4);

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      #(CLK_P * 20000);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule